// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Output Unit

This block is one capture/compare slot that sits beside a shared free-running timer counter. It is not the counter itself. In capture mode it watches one of four selectable sources, which are two input pins and two constant levels. When the chosen edge appears on that source, it stores the current counter value in its channel register. Capture can happen as soon as the edge is seen, or it can wait for the next timer tick. Each capture raises an event flag. A capture that lands while an earlier one is still unread also raises an overflow flag.

In compare mode the channel compares the counter against a compare value. When they match on a timer tick, it pulses an equality strobe and raises the event flag. At the same moment it also records the synchronised level of the selected source. The compare value comes from a double-buffered latch, which refreshes from the channel register only on a chosen load event. A build parameter removes the latch so that the compare reads the channel register directly.

An eight-mode output unit drives the pin. It combines the channel's own match with a period-match strobe from channel 0 to set, reset or toggle the pin. A separate control bit releases the pin driver. The interrupt request is the event flag gated by an enable bit.

Top module: `cc_channel`

## Requirements
- R1: After reset the control word (address 0) and the channel register (address 1) read 0, outPin is 0, outOe is 1, and irq and eqStrobe are 0.
- R2: In capture mode (control bit 5 = 1) the edge field, bits 1:0, selects the capture edge: 00 none, 01 rising, 10 falling, 11 both. An edge that the field does not select is ignored. With bit 4 = 0, a source change that occurs in cycle N is captured at edge N+3. The capture stores counterVal in the channel register and sets the event flag, bit 11.
- R3: A capture taken while the previous capture has not been read (a read of address 1 with regRdEn) sets the overflow flag, bit 12. After such a read, one single capture leaves the overflow flag at 0.
- R4: The source field, bits 3:2, selects capInA (00), capInB (01), constant 0 (10) or constant 1 (11). A change of selection that changes the level counts as an edge.
- R5: With the sync bit, bit 4, set, a detected edge is held until the first cycle with tick = 1. The capture happens at that edge and uses that cycle's counterVal.
- R6: In compare mode, a cycle with tick = 1 and counterVal equal to the compare value produces the following at the next edge: eqStrobe high for that one cycle, the event flag set, and the synchronised source level stored in bit 13.
- R7: The output mode field, bits 8:6, controls the pin on the channel's own match. Mode 0 copies bit 10 to outPin, one edge after the control write takes effect. Mode 1 sets the pin on own match, mode 4 toggles it, and mode 5 resets it.
- R8: Modes 2, 3, 6 and 7 act on own match by toggling, setting, toggling and resetting respectively. On a periodMatch pulse they reset (modes 2 and 3) or set (modes 6 and 7). When both matches occur in the same cycle, the periodMatch action wins.
- R9: With double buffering, a write to the channel register does not affect comparison until a load event copies it into the compare latch. With bit 15 = 1 the load event is a periodMatch pulse. With bit 15 = 0 it is a tick while counterVal is 0.
- R10: Control bit 14 set drives outOe to 0, and clearing it drives outOe back to 1.
- R11: irq is the event flag ANDed with enable bit 9. Software writes bit 11 to set or clear the flag. When a software clear and a hardware event fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on address 1) |
| regAddr | input | 1 | 0 = control word, 1 = channel register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr, combinational |
| counterVal | input | CNT_W | Shared timer counter value |
| tick | input | 1 | Timer clock enable; the counter advances on ticks |
| periodMatch | input | 1 | Channel-0 match strobe |
| capInA | input | 1 | Capture source A |
| capInB | input | 1 | Capture source B |
| outPin | output | 1 | Output unit value |
| outOe | output | 1 | Pad drive enable; 0 means high impedance |
| eqStrobe | output | 1 | One-cycle compare match pulse |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed delay after its stimulus. Register writes show up on the combinational read port in the cycle after the write edge. A compare match, a periodMatch pulse or a tick-aligned capture changes eqStrobe, outPin and the flags at the edge that samples it. An asynchronous capture lands three edges after the source changes, because of the two synchroniser stages and the edge register. A mode 0 pin value follows its control write one edge later. The driver pushes every expected value into the scoreboard with the exact cycle it is due in. The monitor compares it on the falling clock edge of that cycle, and it also checks the cycle just before a capture to show that the result has not come early.

// File: rtl/cc_pkg.sv
package ccPkg;
  localparam int unsigned CTL_W = 16;

  typedef enum logic [2:0] {
    OUT_SW      = 3'd0,
    OUT_SET     = 3'd1,
    OUT_TGL_RST = 3'd2,
    OUT_SET_RST = 3'd3,
    OUT_TGL     = 3'd4,
    OUT_RST     = 3'd5,
    OUT_TGL_SET = 3'd6,
    OUT_RST_SET = 3'd7
  } outMode_t;

  // Control word, MSB first
  typedef struct packed {
    logic       loadOnPeriod; // 15
    logic       hiZ;          // 14
    logic       latchedIn;    // 13 read-only
    logic       ovfFlag;      // 12
    logic       evtFlag;      // 11
    logic       outBit;       // 10
    logic       irqEn;        // 9
    outMode_t   outMode;      // 8:6
    logic       capMode;      // 5
    logic       syncCap;      // 4
    logic [1:0] srcSel;       // 3:2
    logic [1:0] edgeSel;      // 1:0
  } ctlReg_t;

  typedef struct packed {
    logic capture;
    logic ownMatch;
    logic perMatch;
    logic loadLatch;
    logic ccrRead;
    logic ccrWrite;
    logic ctlWrite;
  } strobes_t;
endpackage

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import ccPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capMode,
  input  logic             syncCap,
  input  logic [1:0]       srcSel,
  input  logic [1:0]       edgeSel,
  input  logic             loadOnPeriod,
  input  logic             capInA,
  input  logic             capInB,
  input  logic             tick,
  input  logic             periodMatch,
  input  logic [CNT_W-1:0] counterVal,
  input  logic             counterIsEq,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             regAddr,
  output strobes_t         stb,
  output logic             syncedIn
);
  logic       selIn;
  logic [1:0] syncQ;
  logic       prevIn;
  logic       pendCap;
  logic       riseSeen, fallSeen, edgeHit, capGo;

  always_comb begin
    case (srcSel)
      2'b00:   selIn = capInA;
      2'b01:   selIn = capInB;
      2'b10:   selIn = 1'b0;
      default: selIn = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevIn  <= 1'b0;
      pendCap <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], selIn};
      prevIn  <= syncQ[1];
      pendCap <= capMode & syncCap & (edgeHit | pendCap) & ~capGo;
    end
  end

  assign riseSeen = syncQ[1] & ~prevIn;
  assign fallSeen = ~syncQ[1] & prevIn;
  assign edgeHit  = capMode & ((edgeSel[0] & riseSeen) | (edgeSel[1] & fallSeen));
  assign capGo    = capMode & (edgeHit | pendCap) & (tick | ~syncCap);
  assign syncedIn = syncQ[1];

  always_comb begin
    stb.capture   = capGo;
    stb.ownMatch  = ~capMode & tick & counterIsEq;
    stb.perMatch  = periodMatch;
    stb.loadLatch = loadOnPeriod ? periodMatch : (tick & (counterVal == '0));
    stb.ccrRead   = regRdEn & regAddr;
    stb.ccrWrite  = regWrEn & regAddr;
    stb.ctlWrite  = regWrEn & ~regAddr;
  end
endmodule

// File: rtl/cc_dp.sv
module cc_dp
  import ccPkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit DBUF  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [CNT_W-1:0] counterVal,
  input  logic             syncedIn,
  input  logic             regAddr,
  input  logic [CTL_W-1:0] regWrData,
  output logic [CTL_W-1:0] regRdData,
  output ctlReg_t          ctl,
  output logic             counterIsEq,
  output logic             outVal,
  output logic             eqStrobe
);
  ctlReg_t          wrCtl;
  logic [CNT_W-1:0] ccr;
  logic [CNT_W-1:0] cmpValue;
  logic             unread;
  logic             nextOut;
  logic [CTL_W-1:0] rdCcr;

  assign wrCtl = ctlReg_t'(regWrData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl      <= '0;
      ccr      <= '0;
      unread   <= 1'b0;
      outVal   <= 1'b0;
      eqStrobe <= 1'b0;
    end else begin
      if (stb.ctlWrite) begin
        ctl           <= wrCtl;
        ctl.latchedIn <= ctl.latchedIn;
      end
      if (stb.capture) begin
        ccr         <= counterVal;
        ctl.evtFlag <= 1'b1;
        if (unread) ctl.ovfFlag <= 1'b1;
        unread      <= 1'b1;
      end else begin
        if (stb.ccrWrite) ccr <= regWrData[CNT_W-1:0];
        if (stb.ccrRead)  unread <= 1'b0;
      end
      if (stb.ownMatch) begin
        ctl.evtFlag   <= 1'b1;
        ctl.latchedIn <= syncedIn;
      end
      eqStrobe <= stb.ownMatch;
      outVal   <= nextOut;
    end
  end

  generate
    if (DBUF) begin : gLatch
      logic [CNT_W-1:0] latchQ;
      always_ff @(posedge clk) begin
        if (!rstN)              latchQ <= '0;
        else if (stb.loadLatch) latchQ <= ccr;
      end
      assign cmpValue = latchQ;
    end else begin : gDirect
      assign cmpValue = ccr;
    end
  endgenerate

  assign counterIsEq = (counterVal == cmpValue);

  always_comb begin
    nextOut = outVal;
    case (ctl.outMode)
      OUT_SW:      nextOut = ctl.outBit;
      OUT_SET:     if (stb.ownMatch) nextOut = 1'b1;
      OUT_TGL_RST: begin
        if (stb.ownMatch) nextOut = ~outVal;
        if (stb.perMatch) nextOut = 1'b0;
      end
      OUT_SET_RST: begin
        if (stb.ownMatch) nextOut = 1'b1;
        if (stb.perMatch) nextOut = 1'b0;
      end
      OUT_TGL:     if (stb.ownMatch) nextOut = ~outVal;
      OUT_RST:     if (stb.ownMatch) nextOut = 1'b0;
      OUT_TGL_SET: begin
        if (stb.ownMatch) nextOut = ~outVal;
        if (stb.perMatch) nextOut = 1'b1;
      end
      OUT_RST_SET: begin
        if (stb.ownMatch) nextOut = 1'b0;
        if (stb.perMatch) nextOut = 1'b1;
      end
      default:     nextOut = outVal;
    endcase
  end

  always_comb begin
    rdCcr = '0;
    rdCcr[CNT_W-1:0] = ccr;
    regRdData = regAddr ? rdCcr : CTL_W'(ctl);
  end
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import ccPkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit DBUF  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic             regAddr,
  input  logic [CTL_W-1:0] regWrData,
  output logic [CTL_W-1:0] regRdData,
  input  logic [CNT_W-1:0] counterVal,
  input  logic             tick,
  input  logic             periodMatch,
  input  logic             capInA,
  input  logic             capInB,
  output logic             outPin,
  output logic             outOe,
  output logic             eqStrobe,
  output logic             irq
);
  strobes_t stb;
  ctlReg_t  cfg;
  logic     counterIsEq;
  logic     syncedIn;
  logic     outVal;

  cc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .capMode(cfg.capMode), .syncCap(cfg.syncCap), .srcSel(cfg.srcSel),
    .edgeSel(cfg.edgeSel), .loadOnPeriod(cfg.loadOnPeriod),
    .capInA(capInA), .capInB(capInB), .tick(tick), .periodMatch(periodMatch),
    .counterVal(counterVal), .counterIsEq(counterIsEq),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .stb(stb), .syncedIn(syncedIn)
  );

  cc_dp #(.CNT_W(CNT_W), .DBUF(DBUF)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .counterVal(counterVal),
    .syncedIn(syncedIn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ctl(cfg), .counterIsEq(counterIsEq),
    .outVal(outVal), .eqStrobe(eqStrobe)
  );

  assign outPin = outVal;
  assign outOe  = ~cfg.hiZ;
  assign irq    = cfg.evtFlag & cfg.irqEn;
endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk
  import ccPkg::*;
(
  input logic     clk,
  input logic     rstN,
  input strobes_t stb,
  input ctlReg_t  cfg,
  input logic     outPin,
  input logic     eqStrobe,
  input logic     irq
);
  p_capflag_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> cfg.evtFlag);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.ovfFlag && !stb.ctlWrite) |=> cfg.ovfFlag);

  p_eq_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.ownMatch |=> (eqStrobe && cfg.evtFlag));

  p_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ownMatch && cfg.outMode == OUT_SET) |=> outPin);

  p_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ownMatch && cfg.outMode == OUT_RST) |=> !outPin);

  p_perlow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.perMatch && (cfg.outMode == OUT_TGL_RST || cfg.outMode == OUT_SET_RST)) |=> !outPin);

  p_perhigh_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.perMatch && (cfg.outMode == OUT_TGL_SET || cfg.outMode == OUT_RST_SET)) |=> outPin);

  p_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ownMatch && cfg.irqEn && !stb.ctlWrite) |=> irq);
endmodule

bind cc_channel cc_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg),
  .outPin(outPin), .eqStrobe(eqStrobe), .irq(irq)
);

// File: tb/cc_channel_tb.sv
module cc_channel_tb;
  localparam int CNT_W = 16;
  localparam logic [15:0] EVT = 16'h0800;
  localparam logic [15:0] OVF = 16'h1000;
  localparam logic [15:0] LAT = 16'h2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [CNT_W-1:0] counterVal = '0;
  logic tick = 1'b0, periodMatch = 1'b0, capInA = 1'b0, capInB = 1'b0;
  logic outPin, outOe, eqStrobe, irq;

  cc_channel #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .counterVal(counterVal), .tick(tick), .periodMatch(periodMatch),
    .capInA(capInA), .capInB(capInB), .outPin(outPin), .outOe(outOe),
    .eqStrobe(eqStrobe), .irq(irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc++;

  typedef struct {
    int          due;
    int          sig; // 0 rdData, 1 outPin, 2 outOe, 3 irq, 4 eqStrobe
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  function automatic logic [15:0] actualOf(int sig);
    case (sig)
      0:       return regRdData;
      1:       return {15'd0, outPin};
      2:       return {15'd0, outOe};
      3:       return {15'd0, irq};
      default: return {15'd0, eqStrobe};
    endcase
  endfunction

  // monitor: compares every item that is due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        checks++;
        if (actualOf(sb[i].sig) !== sb[i].exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", sb[i].tag, actualOf(sb[i].sig), sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expectAt(int sig, logic [15:0] exp, int lat, string tag);
    item_t it;
    it.due = cyc + lat; it.sig = sig; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrReg(logic a, logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(1);
    regWrEn = 1'b0;
  endtask

  task automatic chkReg(logic a, logic [15:0] exp, string tag);
    regAddr = a;
    expectAt(0, exp, 0, tag);
    step(1);
  endtask

  task automatic rdCcr();
    regAddr = 1'b1; regRdEn = 1'b1;
    step(1);
    regRdEn = 1'b0;
  endtask

  task automatic matchPulse(logic [15:0] v, bit per);
    counterVal = v; tick = 1'b1; periodMatch = per;
    step(1);
    tick = 1'b0; periodMatch = 1'b0;
  endtask

  task automatic perPulse();
    periodMatch = 1'b1;
    step(1);
    periodMatch = 1'b0;
  endtask

  function automatic logic [15:0] mkCtl(int edgeS, int src, bit sync, bit cap, int mode,
                                        bit ien, bit ob, bit lop, bit hiz);
    logic [15:0] w;
    w = '0;
    w[1:0] = 2'(edgeS); w[3:2] = 2'(src); w[4] = sync; w[5] = cap;
    w[8:6] = 3'(mode); w[9] = ien; w[10] = ob; w[14] = hiz; w[15] = lop;
    return w;
  endfunction

  task automatic setMode(int m, bit ob);
    wrReg(1'b0, mkCtl(0, 3, 0, 0, m, 0, ob, 1, 0));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] base;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expectAt(1, 16'd0, 0, "R1 outPin");
    expectAt(2, 16'd1, 0, "R1 outOe");
    expectAt(3, 16'd0, 0, "R1 irq");
    expectAt(4, 16'd0, 0, "R1 eqStrobe");
    chkReg(1'b0, 16'h0000, "R1 ctl");
    chkReg(1'b1, 16'h0000, "R1 ccr");

    // R4 constant-high source, R2 rising edge, async 3-edge latency
    counterVal = 16'h1234;
    wrReg(1'b0, mkCtl(1, 3, 0, 1, 0, 0, 0, 0, 0));
    regAddr = 1'b1;
    expectAt(0, 16'h0000, 2, "R2 not yet captured");
    expectAt(0, 16'h1234, 3, "R2 capture at third edge");
    step(4);
    chkReg(1'b0, mkCtl(1, 3, 0, 1, 0, 0, 0, 0, 0) | EVT, "R2 event flag");

    // R2 falling edge ignored in rising mode (constant-low source)
    counterVal = 16'h2222;
    wrReg(1'b0, mkCtl(1, 2, 0, 1, 0, 0, 0, 0, 0));
    step(5);
    chkReg(1'b1, 16'h1234, "R2 falling edge ignored");

    // R3 overflow on second unread capture
    wrReg(1'b0, mkCtl(3, 3, 0, 1, 0, 0, 0, 0, 0));
    step(4);
    chkReg(1'b1, 16'h2222, "R2 both-edge capture");
    chkReg(1'b0, mkCtl(3, 3, 0, 1, 0, 0, 0, 0, 0) | EVT | OVF, "R3 overflow set");

    // R3 read clears tracking; R4 input A selection gives falling edge
    rdCcr();
    counterVal = 16'h3333;
    wrReg(1'b0, mkCtl(3, 0, 0, 1, 0, 0, 0, 0, 0));
    step(4);
    chkReg(1'b1, 16'h3333, "R4 switch to input A edge");
    chkReg(1'b0, mkCtl(3, 0, 0, 1, 0, 0, 0, 0, 0) | EVT, "R3 no overflow after read");

    // R4 input B, falling only
    wrReg(1'b0, mkCtl(2, 1, 0, 1, 0, 0, 0, 0, 0));
    step(4);
    capInB = 1'b1;
    step(5);
    chkReg(1'b1, 16'h3333, "R2 rising ignored in falling mode");
    counterVal = 16'h4444;
    capInB = 1'b0;
    step(4);
    chkReg(1'b1, 16'h4444, "R4 input B falling capture");

    // R5 synchronous capture waits for tick
    wrReg(1'b0, mkCtl(1, 0, 1, 1, 0, 0, 0, 0, 0));
    step(4);
    capInA = 1'b1;
    step(6);
    chkReg(1'b1, 16'h4444, "R5 held without tick");
    counterVal = 16'h5555; tick = 1'b1;
    step(1);
    tick = 1'b0;
    chkReg(1'b1, 16'h5555, "R5 captured on tick");

    // R9 / R6 compare with double buffer loaded on period match
    base = mkCtl(0, 3, 0, 0, 0, 1, 0, 1, 0);
    wrReg(1'b0, base);
    wrReg(1'b1, 16'd100);
    step(3);
    matchPulse(16'd100, 0);
    expectAt(4, 16'd0, 0, "R9 latch not yet loaded");
    step(1);
    perPulse();
    matchPulse(16'd100, 0);
    expectAt(4, 16'd1, 0, "R6 eqStrobe pulse");
    expectAt(3, 16'd1, 0, "R11 irq on event");
    expectAt(4, 16'd0, 1, "R6 eqStrobe one cycle");
    step(2);
    chkReg(1'b0, base | EVT | LAT, "R6 flag and latched input");

    // R11 software clear / set / hardware wins
    wrReg(1'b0, base);
    expectAt(3, 16'd0, 0, "R11 software clear");
    step(1);
    wrReg(1'b0, base | EVT);
    expectAt(3, 16'd1, 0, "R11 software set");
    step(1);
    wrReg(1'b0, base);
    step(1);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = base;
    counterVal = 16'd100; tick = 1'b1;
    step(1);
    regWrEn = 1'b0; tick = 1'b0;
    expectAt(3, 16'd1, 0, "R11 hardware set wins");
    step(1);

    // R9 zero-count load event
    wrReg(1'b0, mkCtl(0, 3, 0, 0, 0, 0, 0, 0, 0));
    wrReg(1'b1, 16'd7);
    matchPulse(16'd7, 0);
    expectAt(4, 16'd0, 0, "R9 old latch still used");
    step(1);
    matchPulse(16'd0, 0);
    matchPulse(16'd7, 0);
    expectAt(4, 16'd1, 0, "R9 loaded on zero tick");
    step(1);

    // R7 output modes
    setMode(0, 1);
    expectAt(1, 16'd1, 1, "R7 mode0 high");
    step(2);
    setMode(0, 0);
    expectAt(1, 16'd0, 1, "R7 mode0 low");
    step(2);
    setMode(1, 0);
    matchPulse(16'd7, 0); expectAt(1, 16'd1, 0, "R7 mode1 set"); step(1);
    setMode(5, 0);
    matchPulse(16'd7, 0); expectAt(1, 16'd0, 0, "R7 mode5 reset"); step(1);
    setMode(4, 0);
    matchPulse(16'd7, 0); expectAt(1, 16'd1, 0, "R7 mode4 toggle up"); step(1);
    matchPulse(16'd7, 0); expectAt(1, 16'd0, 0, "R7 mode4 toggle down"); step(1);

    // R8 modes with period match
    setMode(3, 0);
    matchPulse(16'd7, 0); expectAt(1, 16'd1, 0, "R8 mode3 set"); step(1);
    perPulse();           expectAt(1, 16'd0, 0, "R8 mode3 period reset"); step(1);
    setMode(2, 0);
    matchPulse(16'd7, 0); expectAt(1, 16'd1, 0, "R8 mode2 toggle"); step(1);
    matchPulse(16'd7, 0); expectAt(1, 16'd0, 0, "R8 mode2 toggle back"); step(1);
    matchPulse(16'd7, 0); step(1);
    perPulse();           expectAt(1, 16'd0, 0, "R8 mode2 period reset"); step(1);
    matchPulse(16'd7, 0); step(1);
    matchPulse(16'd7, 1); expectAt(1, 16'd0, 0, "R8 mode2 coincident period wins"); step(1);
    setMode(6, 0);
    perPulse();           expectAt(1, 16'd1, 0, "R8 mode6 period set"); step(1);
    matchPulse(16'd7, 0); expectAt(1, 16'd0, 0, "R8 mode6 toggle"); step(1);
    matchPulse(16'd7, 1); expectAt(1, 16'd1, 0, "R8 mode6 coincident period wins"); step(1);
    setMode(7, 0);
    matchPulse(16'd7, 0); expectAt(1, 16'd0, 0, "R8 mode7 reset"); step(1);
    perPulse();           expectAt(1, 16'd1, 0, "R8 mode7 period set"); step(1);
    matchPulse(16'd7, 1); expectAt(1, 16'd1, 0, "R8 mode7 coincident period wins"); step(1);

    // R10 high impedance
    wrReg(1'b0, mkCtl(0, 3, 0, 0, 7, 0, 0, 1, 1));
    expectAt(2, 16'd0, 0, "R10 released"); step(1);
    wrReg(1'b0, mkCtl(0, 3, 0, 0, 7, 0, 0, 1, 0));
    expectAt(2, 16'd1, 0, "R10 driven again"); step(1);

    step(3);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", sb.size());
    end
    finishRun();
  end
endmodule